// File: doc/BRIEF.md
# Serial Capture Frame Builder

This block is the codec side of the input direction of a five-wire audio link. Once per frame it takes a snapshot of the codec state: the ready flag, the register request decoded from the previous output frame, the register readback word, up to eight capture samples with their valid flags, the per-slot sample-request flags and the variable-rate enable. From that snapshot it builds a 256-bit frame and shifts it out MSB first on the serial data line, one bit per rising edge of the bit clock. A frame is a 16-bit tag slot followed by twelve 20-bit slots.

The block is a two-state machine. `ST_IDLE` holds the line low. The transition `idle_to_shift` fires on the clock edge where the frame sync input is first seen high after being low. That edge loads the snapshot and launches the first bit. `ST_SHIFT` sends the remaining 255 bits. It then takes the transition `shift_to_idle` once bit 256 has been on the line for one cycle. A new sync rise while in `ST_SHIFT` takes the transition `shift_restart`, which reloads and starts a fresh frame. With no rise and bits still to send, `shift_hold` stays in `ST_SHIFT`.

The codec-ready flag is sticky. It comes up on the first cycle a clocks-stable indication is seen after reset. While it is low, every bit of the frame is zero and register requests are discarded.

Top module: `acin_serializer`

## Requirements
- R1: The first frame bit is driven on the rising clock edge where `sync` is sampled high after being sampled low (or after reset). The next 255 rising edges each drive one further bit, MSB first. The line is 0 during reset, in idle and after the 256th bit.
- R2: The ready flag is 0 from reset until `clk_stable` is sampled high, and stays 1 from then until reset. Its value at frame start is sent as the first bit (tag bit 15).
- R3: A frame that starts while the ready flag is 0 is all zeros, whatever the request, readback, capture or request-flag inputs carry.
- R4: When a ready frame starts with `req_valid`=1 and `req_read`=1, several fields are set: tag bit 14 (slot 1 valid) and tag bit 13 (slot 2 valid) are 1, slot 1 bits 18..12 carry `req_index`, and slot 2 bits 19..4 carry `reg_data` with bits 3..0 zero.
- R5: When a ready frame starts without a read request (no request, or a write), tag bits 14 and 13 are 0. Slot 1 bits 18..12 and all of slot 2 are 0.
- R6: When `var_rate_en`=1, slot 1 bit 11-i carries `slot_req[i]` (i=0 is slot 3, i=7 is slot 10; 1 means no new sample needed). Slot 1 bits 19 and 3..0 are 0.
- R7: When `var_rate_en`=0, slot 1 bits 11..4 are 0 whatever `slot_req` holds.
- R8: Capture channel i (slot 3+i) sets tag bit 12-i to `cap_valid[i]`. When that flag is 1, the slot's bits 19..2 carry `cap_data[18i+17:18i]` MSB first and bits 1..0 are 0. When it is 0, the whole slot is 0.
- R9: Tag bits 4..0 and slots 11 and 12 are always 0.
- R10: A `sync` rise during a frame abandons it. The edge of the rise drives the first bit of a new frame built from the inputs at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; everything changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset (cold reset) |
| sync | input | 1 | Frame sync from the controller |
| clk_stable | input | 1 | Internal clocks-and-supplies-stable indication |
| req_valid | input | 1 | A register access was decoded from the previous output frame |
| req_read | input | 1 | That access was a read (0 = write) |
| req_index | input | 7 | Register index of the access |
| reg_data | input | 16 | Readback data for the requested register |
| cap_data | input | 144 | Eight 18-bit capture samples, channel i at bits 18i+17..18i |
| cap_valid | input | 8 | Per-channel capture valid flags |
| slot_req | input | 8 | Per-channel sample-request flags |
| var_rate_en | input | 1 | Variable-rate enable; gates the request flags |
| ser_out | output | 1 | Serial frame data toward the controller |

## Verification
The bench uses the default parameters: 18-bit capture words in eight channels, a 7-bit index and a 16-bit readback word. This gives the full 256-bit frame with every tag position in use. Because all eight capture channels are present, mixed valid patterns and the edge channels 0 and 7 can reach both ends of the tag field and both ends of the request field. The short frame allows many frames, several ready/not-ready transitions and mid-frame restarts within the run. It also allows idle gaps of varying length between sync pulses.

// File: rtl/acin_pkg.sv
package acin_pkg;
    localparam int TAG_W     = 16;
    localparam int SLOT_W    = 20;
    localparam int NUM_SLOTS = 12;
    localparam int FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W;
    localparam int CNT_W     = $clog2(FRAME_BITS + 1);

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } ser_state_t;
endpackage

// File: rtl/acin_ready_track.sv
module acin_ready_track (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_stable,
    output logic ready
);
    always_ff @(posedge clk) begin
        if (!rst_n) ready <= 1'b0;
        else        ready <= ready | clk_stable;
    end

    // R2: once up, the flag only falls through reset
    a_r2_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
endmodule

// File: rtl/acin_frame_build.sv
module acin_frame_build
    import acin_pkg::*;
#(
    parameter int IDX_W   = 7,
    parameter int REG_W   = 16,
    parameter int CAP_W   = 18,
    parameter int NUM_CAP = 8
) (
    input  logic                     ready,
    input  logic                     req_valid,
    input  logic                     req_read,
    input  logic [IDX_W-1:0]         req_index,
    input  logic [REG_W-1:0]         reg_data,
    input  logic [NUM_CAP*CAP_W-1:0] cap_data,
    input  logic [NUM_CAP-1:0]       cap_valid,
    input  logic [NUM_CAP-1:0]       slot_req,
    input  logic                     var_rate_en,
    output logic [FRAME_BITS-1:0]    frame
);
    localparam int TOP    = FRAME_BITS - 1;
    localparam int S1_TOP = TOP - TAG_W;
    localparam int S2_TOP = S1_TOP - SLOT_W;
    localparam int S3_TOP = S2_TOP - SLOT_W;
    localparam int IDX_TOP = S1_TOP - 1;
    localparam int SR_TOP  = IDX_TOP - IDX_W;

    logic echo;
    assign echo = ready & req_valid & req_read;

    always_comb begin
        frame = '0;
        if (ready) begin
            frame[TOP]     = 1'b1;
            frame[TOP - 1] = echo;
            frame[TOP - 2] = echo;
            if (echo) begin
                frame[IDX_TOP -: IDX_W] = req_index;
                frame[S2_TOP -: REG_W]  = reg_data;
            end
            for (int i = 0; i < NUM_CAP; i++) begin
                frame[SR_TOP - i] = var_rate_en & slot_req[i];
                frame[TOP - 3 - i] = cap_valid[i];
                if (cap_valid[i])
                    frame[S3_TOP - i*SLOT_W -: CAP_W] = cap_data[i*CAP_W +: CAP_W];
            end
        end
    end
endmodule

// File: rtl/acin_serializer.sv
module acin_serializer
    import acin_pkg::*;
#(
    parameter int IDX_W   = 7,
    parameter int REG_W   = 16,
    parameter int CAP_W   = 18,
    parameter int NUM_CAP = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sync,
    input  logic                     clk_stable,
    input  logic                     req_valid,
    input  logic                     req_read,
    input  logic [IDX_W-1:0]         req_index,
    input  logic [REG_W-1:0]         reg_data,
    input  logic [NUM_CAP*CAP_W-1:0] cap_data,
    input  logic [NUM_CAP-1:0]       cap_valid,
    input  logic [NUM_CAP-1:0]       slot_req,
    input  logic                     var_rate_en,
    output logic                     ser_out
);
    localparam int TOP = FRAME_BITS - 1;
    localparam int SR_TOP = TOP - TAG_W - 1 - IDX_W;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS);

    ser_state_t              state_q, state_d;
    logic [CNT_W-1:0]        cnt_q;
    logic [FRAME_BITS-1:0]   shreg_q;
    logic [FRAME_BITS-1:0]   frame;
    logic                    sync_q;
    logic                    ser_q;
    logic                    rdy;
    logic                    start;

    assign start   = sync & ~sync_q;
    assign ser_out = ser_q;

    acin_ready_track u_rdy (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_stable (clk_stable),
        .ready      (rdy)
    );

    acin_frame_build #(
        .IDX_W   (IDX_W),
        .REG_W   (REG_W),
        .CAP_W   (CAP_W),
        .NUM_CAP (NUM_CAP)
    ) u_build (
        .ready       (rdy),
        .req_valid   (req_valid),
        .req_read    (req_read),
        .req_index   (req_index),
        .reg_data    (reg_data),
        .cap_data    (cap_data),
        .cap_valid   (cap_valid),
        .slot_req    (slot_req),
        .var_rate_en (var_rate_en),
        .frame       (frame)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = start ? ST_SHIFT : ST_IDLE;
            ST_SHIFT: begin
                if (start)              state_d = ST_SHIFT;
                else if (cnt_q == LAST) state_d = ST_IDLE;
                else                    state_d = ST_SHIFT;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sync_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            sync_q  <= sync;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_q   <= 1'b0;
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (start) begin
            ser_q   <= frame[TOP];
            shreg_q <= frame << 1;
            cnt_q   <= CNT_W'(1);
        end else if (state_q == ST_SHIFT && cnt_q != LAST) begin
            ser_q   <= shreg_q[TOP];
            shreg_q <= shreg_q << 1;
            cnt_q   <= cnt_q + 1'b1;
        end else begin
            ser_q   <= 1'b0;
        end
    end

    a_r2_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ser_out == $past(rdy));
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> !ser_out);
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    a_r3_unready_blank: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> frame == '0);
    a_r5_no_echo_tags: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_read) |-> (!frame[TOP-1] && !frame[TOP-2]));
    a_r7_requests_off: assert property (@(posedge clk) disable iff (!rst_n)
        !var_rate_en |-> frame[SR_TOP -: NUM_CAP] == '0);
endmodule

// File: tb/sim_acin_serializer.sv
module sim_acin_serializer;
    localparam int CLK_PERIOD = 10;
    localparam int NCAP = 8;
    localparam int CW = 18;

    logic clk = 0, rst_n = 0, sync = 0, clk_stable = 0;
    logic req_valid = 0, req_read = 0, var_rate_en = 0;
    logic [6:0] req_index = 0;
    logic [15:0] reg_data = 0;
    logic [NCAP*CW-1:0] cap_data = 0;
    logic [NCAP-1:0] cap_valid = 0, slot_req = 0;
    logic ser_out;

    int vectors = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acin_serializer u0 (
        .clk(clk), .rst_n(rst_n), .sync(sync), .clk_stable(clk_stable),
        .req_valid(req_valid), .req_read(req_read), .req_index(req_index),
        .reg_data(reg_data), .cap_data(cap_data), .cap_valid(cap_valid),
        .slot_req(slot_req), .var_rate_en(var_rate_en), .ser_out(ser_out)
    );

    // behavioural reference: a queue of expected bits
    bit q[$];
    bit exp_bit, m_rdy, m_sync, f_rdy, f_vra, f_restart;
    int pos = -1;

    task automatic push_val(input logic [31:0] v, input int w);
        for (int k = w - 1; k >= 0; k--) q.push_back(v[k]);
    endtask

    task automatic build_frame();
        bit echo;
        q.delete();
        echo = m_rdy && req_valid && req_read;
        if (!m_rdy) begin
            for (int k = 0; k < 256; k++) q.push_back(1'b0);
            return;
        end
        // tag slot
        q.push_back(1'b1);
        q.push_back(echo);
        q.push_back(echo);
        for (int c = 0; c < NCAP; c++) q.push_back(cap_valid[c]);
        push_val(0, 5);
        // slot 1
        q.push_back(1'b0);
        push_val(echo ? req_index : 7'd0, 7);
        for (int c = 0; c < NCAP; c++) q.push_back(var_rate_en && slot_req[c]);
        push_val(0, 4);
        // slot 2
        push_val(echo ? reg_data : 16'd0, 16);
        push_val(0, 4);
        // capture slots
        for (int c = 0; c < NCAP; c++) begin
            push_val(cap_valid[c] ? cap_data[c*CW +: CW] : 18'd0, 18);
            push_val(0, 2);
        end
        push_val(0, 20);
        push_val(0, 20);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); exp_bit = 0; m_rdy = 0; m_sync = 0; pos = -1;
        end else begin
            if (sync && !m_sync) begin
                f_restart = (q.size() > 0);
                f_rdy = m_rdy; f_vra = var_rate_en;
                build_frame();
                pos = -1;
            end
            if (q.size() > 0) begin
                exp_bit = q.pop_front();
                pos++;
            end else begin
                exp_bit = 0;
                pos = -1;
            end
            m_rdy = m_rdy | clk_stable;
            m_sync = sync;
        end
    end

    function automatic string req_of(int p);
        if (p < 0) return "R1";
        if (f_restart) return "R10";
        if (p == 0) return "R2";
        if (!f_rdy) return "R3";
        if (p >= 3 && p <= 10) return "R8";
        if (p >= 24 && p <= 31) return f_vra ? "R6" : "R7";
        if (p == 16 || (p >= 32 && p <= 35)) return "R6";
        if (p < 16 && p > 10) return "R9";
        if (p < 56) return "R4";
        if (p < 216) return "R8";
        return "R9";
    endfunction

    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (ser_out !== (rst_n ? exp_bit : 1'b0)) begin
                fails++;
                $display("FAIL %s bit %0d at %0t: got %b expected %b",
                         rst_n ? req_of(pos) : "R1", pos, $time, ser_out, exp_bit);
            end
        end
    end

    task automatic pulse_sync(input int high_cycles);
        @(negedge clk) sync = 1;
        repeat (high_cycles) @(negedge clk);
        sync = 0;
    endtask

    task automatic run_frame(input int gap);
        pulse_sync(2);
        repeat (256 + gap) @(negedge clk);
    endtask

    task automatic rand_caps();
        for (int c = 0; c < NCAP; c++) cap_data[c*CW +: CW] = CW'($urandom);
        cap_valid = NCAP'($urandom);
        slot_req  = NCAP'($urandom);
    endtask

    initial begin
        repeat (4) @(negedge clk);          // R1 reset state checked every cycle
        rst_n = 1;
        repeat (3) @(negedge clk);
        // R3: not ready, read request and data present
        req_valid = 1; req_read = 1; req_index = 7'h26; reg_data = 16'hA5C3;
        cap_valid = 8'hFF; cap_data = {NCAP*CW{1'b1}}; slot_req = 8'hFF; var_rate_en = 1;
        run_frame(5);
        // R2: ready comes up mid-idle
        @(negedge clk) clk_stable = 1;
        @(negedge clk) clk_stable = 0;
        // R4 read echo, R6 request flags, R8 all valid
        req_index = 7'h7F; reg_data = 16'hFFFF; slot_req = 8'b1000_0001;
        run_frame(3);
        // R5 write, R7 variable rate off
        req_read = 0; var_rate_en = 0; slot_req = 8'hFF; cap_valid = 8'b1000_0001;
        run_frame(0);
        // R5 no request
        req_valid = 0; req_read = 1; cap_valid = 8'h00;
        run_frame(7);
        // mixed patterns
        for (int n = 0; n < 12; n++) begin
            rand_caps();
            req_valid = 1'($urandom); req_read = 1'($urandom);
            req_index = 7'($urandom); reg_data = 16'($urandom);
            var_rate_en = 1'($urandom);
            run_frame(n % 4);
        end
        // R10: restart mid-frame
        req_valid = 1; req_read = 1; var_rate_en = 1; rand_caps();
        pulse_sync(1);
        repeat (90) @(negedge clk);
        req_index = 7'h11; rand_caps();
        run_frame(4);
        // sync held high across the frame end: no second frame (R1)
        @(negedge clk) sync = 1;
        repeat (300) @(negedge clk);
        sync = 0;
        repeat (5) @(negedge clk);
        // R2 sticky through frames, reset drops it (R3 after reset)
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        run_frame(4);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL R1 watchdog expired: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule